// File: doc/BRIEF.md
# Enable-Masked Stream Sample Unpacker

This block takes a stream of packed words, each carrying `NUM_CH` samples of `SAMPLE_W` bits, and spreads the samples over `NUM_CH` channel output ports. A per-channel enable mask chooses which channels take part. One shared read-request strobe serves every channel. On each request the block hands the oldest buffered samples to the enabled channels, lowest channel first. One cycle after the request it answers with a single-cycle valid pulse, or with a single-cycle underflow pulse if too few samples were buffered.

The input is a valid/ready stream. A word moves when `s_valid` and `s_ready` are both high at a rising clock edge. The block raises `s_ready` only when its buffer holds fewer samples than one request would use, so it draws words only as requests need them. The upstream source may present a word at any time and must hold it until it is accepted. Nothing is lost when ready is low. The request strobe, the mask and the two response flags are plain level and pulse signals with no handshake. Enabled ports carry meaningful data only in the cycle where `rd_valid` is high. Disabled ports never do.

Top module: `stream_unpacker`

## Requirements
- R1: While `rst` is high, and after it, `rd_valid`, `rd_underflow` and `s_ready` are low and the buffer is empty. A request after reset with a non-zero mask, made before any word is accepted, gives underflow.
- R2: Outside reset, `s_ready` is high exactly when the buffered sample count is less than the number of set bits in `ch_enable`.
- R3: An accepted word appends its `NUM_CH` samples to the buffer. The sample in bits `[SAMPLE_W-1:0]` comes first, then increasing slots.
- R4: A request made when the buffered count is at least the number of enabled channels gives `rd_valid` high in the next cycle, for that cycle only.
- R5: On a served request, enabled channel c receives, in its slice `rd_data[c*SAMPLE_W +: SAMPLE_W]`, the sample that follows in age order. The oldest sample goes to the lowest enabled channel. Exactly as many samples leave the buffer as there are enabled channels.
- R6: A request made when the buffered count is below the number of enabled channels gives `rd_underflow` high in the next cycle for one cycle and consumes no sample.
- R7: `rd_valid` and `rd_underflow` are never high together. Either one is high only in the cycle after a request.
- R8: Every mask value unpacks correctly, including all-zero. With an all-zero mask every request gives `rd_valid`, consumes nothing, and `s_ready` stays low.
- R9: A word accepted in the same cycle as an underflowing request is kept. A later request is served from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | NUM_CH*SAMPLE_W | Packed input word, slot 0 in the low bits |
| s_valid | input | 1 | Input word present |
| s_ready | output | 1 | Block accepts the input word |
| ch_enable | input | NUM_CH | Per-channel enable mask, bit c for channel c |
| rd_req | input | 1 | Shared read request |
| rd_data | output | NUM_CH*SAMPLE_W | Channel c output in bits c*SAMPLE_W upward |
| rd_valid | output | 1 | Enabled channel outputs hold data (one cycle) |
| rd_underflow | output | 1 | Request could not be served (one cycle) |

## Verification
A wrong buffer count shows up in the same cycle as a wrong level on `s_ready`. It also shows up one cycle after the next request, as a flag of the wrong kind. A wrong shift or rank computation puts samples on the wrong channels or in the wrong age order, and this appears in the first valid response that uses the affected slots. A word that is lost or duplicated shifts every later sample, so the bench's sample-by-sample comparison against its reference queue catches it on the very next served request.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  typedef enum logic [1:0] {
    RESP_IDLE  = 2'd0,
    RESP_DATA  = 2'd1,
    RESP_UFLOW = 2'd2
  } resp_e;

  function automatic resp_e decide(input logic req, input logic enough);
    if (!req)       return RESP_IDLE;
    else if (enough) return RESP_DATA;
    else            return RESP_UFLOW;
  endfunction
endpackage

// File: rtl/unpk_route.sv
module unpk_route #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 2 * NUM_CH,
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*SAMPLE_W-1:0]  buf_flat,
  input  logic [NUM_CH-1:0]          mask,
  output logic [NUM_CH*SAMPLE_W-1:0] sel_flat,
  output logic [CW-1:0]              need
);
  localparam int RW = $clog2(NUM_CH + 1);

  always_comb begin
    need = '0;
    for (int k = 0; k < NUM_CH; k++) need = need + CW'(mask[k]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [RW-1:0] rank;
    always_comb begin
      rank = '0;
      for (int k = 0; k < c; k++) rank = rank + RW'(mask[k]);
    end
    assign sel_flat[c*SAMPLE_W +: SAMPLE_W] = buf_flat[int'(rank)*SAMPLE_W +: SAMPLE_W];
  end
endmodule

// File: rtl/unpk_store.sv
module unpk_store #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16,
  parameter int DEPTH    = 2 * NUM_CH,
  parameter int CW       = $clog2(DEPTH + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       pop,
  input  logic [CW-1:0]              pop_n,
  input  logic                       push,
  input  logic [NUM_CH*SAMPLE_W-1:0] push_word,
  output logic [DEPTH*SAMPLE_W-1:0]  buf_flat,
  output logic [CW-1:0]              cnt
);
  logic [SAMPLE_W-1:0] slot_q  [DEPTH];
  logic [SAMPLE_W-1:0] slot_nx [DEPTH];
  logic [CW-1:0]       cnt_q, cnt_nx;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) slot_nx[i] = slot_q[i];
    cnt_nx = cnt_q;
    if (pop) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i + int'(pop_n) < DEPTH) slot_nx[i] = slot_q[i + int'(pop_n)];
        else                         slot_nx[i] = '0;
      end
      cnt_nx = cnt_q - pop_n;
    end else if (push) begin
      for (int j = 0; j < NUM_CH; j++) begin
        if (int'(cnt_q) + j < DEPTH)
          slot_nx[int'(cnt_q) + j] = push_word[j*SAMPLE_W +: SAMPLE_W];
      end
      cnt_nx = cnt_q + CW'(NUM_CH);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      cnt_q <= cnt_nx;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_nx[i];
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_flat
    assign buf_flat[i*SAMPLE_W +: SAMPLE_W] = slot_q[i];
  end
  assign cnt = cnt_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) < DEPTH);
  assert_push_grows_R3: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> int'(cnt_q) == int'($past(cnt_q)) + NUM_CH);
  assert_no_pop_push_R2: assert property (@(posedge clk) disable iff (rst)
    !(pop && push));
endmodule

// File: rtl/unpk_resp.sv
module unpk_resp #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  unpk_pkg::resp_e            resp,
  input  logic [NUM_CH-1:0]          mask,
  input  logic [NUM_CH*SAMPLE_W-1:0] sel_flat,
  output logic [NUM_CH*SAMPLE_W-1:0] data,
  output logic                       valid,
  output logic                       uflow
);
  import unpk_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      uflow <= 1'b0;
    end else begin
      valid <= (resp == RESP_DATA);
      uflow <= (resp == RESP_UFLOW);
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    always_ff @(posedge clk) begin
      if (rst) data[c*SAMPLE_W +: SAMPLE_W] <= '0;
      else if (resp == RESP_DATA && mask[c])
        data[c*SAMPLE_W +: SAMPLE_W] <= sel_flat[c*SAMPLE_W +: SAMPLE_W];
    end
  end

  assert_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(valid && uflow));
  assert_pulse_valid_R4: assert property (@(posedge clk) disable iff (rst)
    (valid && $past(resp) != RESP_DATA) |-> 1'b0);
endmodule

// File: rtl/stream_unpacker.sv
module stream_unpacker #(
  parameter int NUM_CH   = 4,
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH*SAMPLE_W-1:0] s_data,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [NUM_CH-1:0]          ch_enable,
  input  logic                       rd_req,
  output logic [NUM_CH*SAMPLE_W-1:0] rd_data,
  output logic                       rd_valid,
  output logic                       rd_underflow
);
  import unpk_pkg::*;

  localparam int DEPTH = 2 * NUM_CH;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [DEPTH*SAMPLE_W-1:0]  buf_flat;
  logic [NUM_CH*SAMPLE_W-1:0] sel_flat;
  logic [CW-1:0]              cnt, need;
  logic                       enough, push, pop;
  resp_e                      resp;

  assign enough  = (cnt >= need);
  assign s_ready = !rst && !enough;
  assign push    = s_valid && s_ready;
  assign resp    = decide(rd_req, enough);
  assign pop     = (resp == RESP_DATA);

  unpk_route #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .CW(CW)) u_route (
    .buf_flat (buf_flat),
    .mask     (ch_enable),
    .sel_flat (sel_flat),
    .need     (need)
  );

  unpk_store #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH), .CW(CW)) u_store (
    .clk       (clk),
    .rst       (rst),
    .pop       (pop),
    .pop_n     (need),
    .push      (push),
    .push_word (s_data),
    .buf_flat  (buf_flat),
    .cnt       (cnt)
  );

  unpk_resp #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_resp (
    .clk      (clk),
    .rst      (rst),
    .resp     (resp),
    .mask     (ch_enable),
    .sel_flat (sel_flat),
    .data     (rd_data),
    .valid    (rd_valid),
    .uflow    (rd_underflow)
  );

  assert_flag_after_req_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid || rd_underflow) |-> $past(rd_req));
  assert_uflow_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !enough && !s_valid) |=> $stable(cnt));
  assert_served_next_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_req && enough) |=> rd_valid);
  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (rst)
    (ch_enable == '0) |-> !s_ready);
  assert_keep_word_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_req && push) |=> (rd_underflow && cnt != '0));
endmodule

// File: tb/sim_stream_unpacker.sv
module sim_stream_unpacker;
  localparam int N = 4;
  localparam int W = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N*W-1:0] s_data = '0;
  logic           s_valid = 1'b0;
  logic           s_ready;
  logic [N-1:0]   ch_enable = '0;
  logic           rd_req = 1'b0;
  logic [N*W-1:0] rd_data;
  logic           rd_valid, rd_underflow;

  int total = 0, bad = 0;
  bit done = 0;

  logic [W-1:0] q[$];
  logic         exp_valid = 0, exp_uf = 0;
  logic [N-1:0] exp_mask = '0;
  logic [W-1:0] exp_data [N];

  always #10 clk = ~clk;

  stream_unpacker #(.NUM_CH(N), .SAMPLE_W(W)) u0 (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .ch_enable(ch_enable), .rd_req(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_underflow(rd_underflow));

  function automatic int ones(input logic [N-1:0] m);
    int k = 0;
    for (int i = 0; i < N; i++) k += int'(m[i]);
    return k;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: compare previous prediction, drive, check ready, predict
  task automatic step(input logic req, input logic inv, input logic [N*W-1:0] word,
                      input logic [N-1:0] mask);
    int k;
    logic rdy;
    @(negedge clk);
    chk("R4/R7 valid", W'(rd_valid), W'(exp_valid));
    chk("R6/R7 underflow", W'(rd_underflow), W'(exp_uf));
    if (exp_valid)
      for (int c = 0; c < N; c++)
        if (exp_mask[c]) chk("R5 channel data", rd_data[c*W +: W], exp_data[c]);
    rd_req = req; s_valid = inv; s_data = word; ch_enable = mask;
    #1;
    k = ones(mask);
    rdy = (q.size() < k);
    chk("R2 ready", W'(s_ready), W'(rdy));
    exp_valid = 0; exp_uf = 0; exp_mask = mask;
    if (req) begin
      if (q.size() >= k) begin
        exp_valid = 1;
        for (int c = 0; c < N; c++) if (mask[c]) exp_data[c] = q.pop_front();
      end else exp_uf = 1;
    end
    if (inv && rdy)
      for (int j = 0; j < N; j++) q.push_back(word[j*W +: W]); // R3 slot order
  endtask

  function automatic logic [N*W-1:0] rword();
    logic [N*W-1:0] v;
    for (int j = 0; j < N; j++) v[j*W +: W] = W'($urandom());
    return v;
  endfunction

  initial begin
    #4000000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // R1: outputs low during reset
    repeat (3) begin
      @(negedge clk);
      chk("R1 ready in reset", W'(s_ready), 0);
      chk("R1 valid in reset", W'(rd_valid), 0);
      chk("R1 underflow in reset", W'(rd_underflow), 0);
    end
    rst = 1'b0;
    // R1: empty after reset -> underflow
    step(1, 0, '0, 4'b1111);
    // R9: underflowing request with a same-cycle word
    step(1, 1, {16'h4444, 16'h3333, 16'h2222, 16'h1111}, 4'b0101);
    step(1, 0, '0, 4'b0101);   // R5: ch0=1111, ch2=2222
    // R8: all-zero mask
    step(1, 1, rword(), 4'b0000);
    step(1, 0, '0, 4'b0000);
    // single channel, then full mask
    step(1, 0, '0, 4'b1000);
    step(1, 0, '0, 4'b1111);   // only one left -> underflow (R6)
    step(0, 1, rword(), 4'b1111);
    step(1, 0, '0, 4'b1111);
    // every mask value
    for (int m = 0; m < (1 << N); m++) begin
      step(0, 1, rword(), N'(m));
      step(1, 0, '0, N'(m));
      step(1, 0, '0, N'(m));
    end
    // constrained random
    begin
      logic [N-1:0] m = 4'b1011;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(0, 40) == 0) m = N'($urandom());
        step(($urandom_range(0, 2) != 0), ($urandom_range(0, 3) != 0), rword(), m);
      end
    end
    step(0, 0, '0, 4'b1111);
    // R1: reset mid-stream empties the buffer
    @(negedge clk); rst = 1'b1; rd_req = 0; s_valid = 0;
    @(negedge clk); chk("R1 ready in reset", W'(s_ready), 0);
    rst = 1'b0;
    q.delete(); exp_valid = 0; exp_uf = 0;
    step(1, 0, '0, 4'b0001);
    step(0, 0, '0, 4'b0001);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule